// File: doc/BRIEF.md
# Fixed-Length Prioritized Block Assembler

This block builds the outgoing data blocks of a multi-channel recorder. Each block opens with eight 24-bit session header words. The header carries a split 29-bit sync pattern, the master clock value, a running block number, the BCD date and time, the block-marker divisor, a word of session flags and a user/version word. After the header, the block carries one packet from each active channel. Channel index 0 has the highest priority and is served first. In fixed-rate mode, all-ones fill words pad the block out to its fixed length.

Space is handed out by strict priority. Each channel may use whatever room the channels ahead of it left. When the block reaches its last word, the current packet is cut and the remaining channels are not read during that block. Packets arrive on per-channel streams with a valid/ready handshake and an end-of-packet flag. The block emits one registered word stream with a valid strobe and a marker on the first word of each block. While `run` is held high, blocks follow each other back to back. When `run` is low at the end of a block, the stream stops.

Top module: `blkasm_top`

## Requirements
- R1: In fixed-rate mode (`fill_en`=1) every block holds exactly BLOCK_WORDS (2048) output words. In variable-rate mode (`fill_en`=0) the block ends with the final word of the last served packet.
- R2: Word 0 of a block is 0x36E19C and is the only word flagged by `out_sob`. Bits 23:19 of word 1 are 01001, and bits 18:0 of word 1 carry `sess_mclk`.
- R3: Word 2 is the block number. It is 0 in the first block after `run` starts a session from idle and rises by one in each following block of the session.
- R4: Words 3, 4 and 5 carry `sess_date`, `sess_time` and `sess_div`. Word 6 is {`sess_clk_int`, `act_m1`, 2'b00, `sess_start_sec`}. Word 7 is {`sess_user`, 10'b0, `sess_ver`}.
- R5: All session inputs are captured at the start of each block. A change made during a block first shows up in the next block.
- R6: Channel packets start at word 8 in ascending channel index. Only channels 0 to min(`act_m1`, NCH-1) are served, and an unserved channel never sees `ch_ready`.
- R7: Every accepted channel word appears unchanged on `out_data` in the cycle after its handshake. Words keep their order of acceptance.
- R8: A packet that reaches the last word of the block is cut there. No channel is given `ch_ready` for the rest of that block.
- R9: At most one `ch_ready` bit is high at a time, and only while channel packets are being collected.
- R10: In fixed-rate mode, every word after the last served packet is 0xFFFFFF.
- R11: During and after reset, `out_valid`, `out_sob` and `ch_ready` are low. If `run` is low when a block ends, no further words are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start a session from idle; sampled at each block end to continue |
| fill_en | input | 1 | 1 = fixed-rate (pad with fill), 0 = variable-rate |
| sess_mclk | input | 19 | Master clock value, units of 250 Hz |
| sess_div | input | 24 | Block-marker divisor |
| sess_date | input | 24 | BCD date YYMMDD |
| sess_time | input | 24 | BCD time HHMMSS |
| sess_clk_int | input | 1 | Master clock source flag (1 = internal) |
| act_m1 | input | 4 | Active channel count minus one |
| sess_start_sec | input | 17 | Session start second of day |
| sess_user | input | 8 | User byte |
| sess_ver | input | 6 | Format version |
| ch_data | input | NCH*24 | Channel words, channel i in bits i*24 +: 24 |
| ch_valid | input | NCH | Channel word valid |
| ch_last | input | NCH | Final word of the channel's packet |
| ch_ready | output | NCH | Channel word accepted this cycle when valid |
| out_data | output | 24 | Output word |
| out_valid | output | 1 | Output word valid |
| out_sob | output | 1 | First word of a block |

## Verification
The checker checks four things on every cycle. The block marker must coincide with the low sync word, and the high sync bits must follow it one cycle later. No more than one channel may be granted at a time. No block may grow past its fixed length. Each accepted channel word must reach the output one cycle later, unchanged. The bench scenarios cover the behaviour that depends on a whole block: the exact block length in both rate modes, the header field layout, the block numbers across a session, and when mid-block configuration changes take effect. They also cover the priority budget: truncation of a packet at the block boundary and skipping of inactive or starved channels, seen through the words each source had accepted.

// File: rtl/blkasm_pkg.sv
package blkasm_pkg;
  localparam int WORD_W = 24;
  localparam int HDR_WORDS = 8;
  localparam logic [23:0] SYNC_LO = 24'h36E19C;
  localparam logic [4:0]  SYNC_HI = 5'b01001;
  localparam logic [23:0] FILL_WORD = 24'hFFFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_CHAN, ST_FILL} phase_t;

  typedef struct packed {
    logic [18:0] mclk;
    logic [23:0] div;
    logic [23:0] date;
    logic [23:0] tod;
    logic        clk_int;
    logic [3:0]  act_m1;
    logic [16:0] start_sec;
    logic [7:0]  user;
    logic [5:0]  ver;
  } sess_cfg_t;
endpackage

// File: rtl/blkasm_hdr.sv
module blkasm_hdr
  import blkasm_pkg::*;
(
  input  sess_cfg_t   cfg,
  input  logic [23:0] blk_num,
  input  logic [2:0]  idx,
  output logic [23:0] word
);
  always_comb begin
    case (idx)
      3'd0:    word = SYNC_LO;
      3'd1:    word = {SYNC_HI, cfg.mclk};
      3'd2:    word = blk_num;
      3'd3:    word = cfg.date;
      3'd4:    word = cfg.tod;
      3'd5:    word = cfg.div;
      3'd6:    word = {cfg.clk_int, cfg.act_m1, 2'b00, cfg.start_sec};
      default: word = {cfg.user, 10'd0, cfg.ver};
    endcase
  end
endmodule

// File: rtl/blkasm_chsel.sv
module blkasm_chsel
  import blkasm_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic [NCH*WORD_W-1:0] data,
  input  logic [NCH-1:0]        valid,
  input  logic [NCH-1:0]        last,
  input  logic [CH_W-1:0]       sel,
  input  logic                  en,
  output logic [NCH-1:0]        ready,
  output logic [WORD_W-1:0]     sel_data,
  output logic                  sel_valid,
  output logic                  sel_last
);
  // grant decode: one ready line per channel
  for (genvar gi = 0; gi < NCH; gi++) begin : g_rdy
    assign ready[gi] = en && (sel == CH_W'(gi));
  end

  always_comb begin
    sel_data  = '0;
    sel_valid = 1'b0;
    sel_last  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == CH_W'(i)) begin
        sel_data  = data[i*WORD_W +: WORD_W];
        sel_valid = en && valid[i];
        sel_last  = last[i];
      end
    end
  end
endmodule

// File: rtl/blkasm_top.sv
module blkasm_top
  import blkasm_pkg::*;
#(
  parameter int BLOCK_WORDS = 2048,
  parameter int NCH         = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  fill_en,
  input  logic [18:0]           sess_mclk,
  input  logic [23:0]           sess_div,
  input  logic [23:0]           sess_date,
  input  logic [23:0]           sess_time,
  input  logic                  sess_clk_int,
  input  logic [3:0]            act_m1,
  input  logic [16:0]           sess_start_sec,
  input  logic [7:0]            sess_user,
  input  logic [5:0]            sess_ver,
  input  logic [NCH*WORD_W-1:0] ch_data,
  input  logic [NCH-1:0]        ch_valid,
  input  logic [NCH-1:0]        ch_last,
  output logic [NCH-1:0]        ch_ready,
  output logic [WORD_W-1:0]     out_data,
  output logic                  out_valid,
  output logic                  out_sob
);
  localparam int POS_W = $clog2(BLOCK_WORDS);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLOCK_WORDS - 1);
  localparam logic [POS_W-1:0] HDR_LAST = POS_W'(HDR_WORDS - 1);

  phase_t            phase;
  logic [POS_W-1:0]  pos;
  logic [CH_W-1:0]   ch, last_ch, last_ch_in;
  logic [23:0]       blk_num;
  sess_cfg_t         cfg_q, cfg_in;
  logic [23:0]       hdr_word;
  logic [WORD_W-1:0] sel_data;
  logic              sel_valid, sel_last;
  logic              end_blk, adv_ch, to_fill;

  assign cfg_in = '{mclk: sess_mclk, div: sess_div, date: sess_date, tod: sess_time,
                    clk_int: sess_clk_int, act_m1: act_m1, start_sec: sess_start_sec,
                    user: sess_user, ver: sess_ver};

  // highest served channel index, clamped to the instantiated channels
  always_comb begin
    if (int'(act_m1) >= NCH - 1) last_ch_in = CH_W'(NCH - 1);
    else                         last_ch_in = CH_W'(act_m1);
  end

  blkasm_hdr u_hdr (
    .cfg     (cfg_q),
    .blk_num (blk_num),
    .idx     (pos[2:0]),
    .word    (hdr_word)
  );

  blkasm_chsel #(.NCH(NCH), .CH_W(CH_W)) u_sel (
    .data      (ch_data),
    .valid     (ch_valid),
    .last      (ch_last),
    .sel       (ch),
    .en        (phase == ST_CHAN),
    .ready     (ch_ready),
    .sel_data  (sel_data),
    .sel_valid (sel_valid),
    .sel_last  (sel_last)
  );

  // block sequencing decisions
  always_comb begin
    end_blk = 1'b0;
    adv_ch  = 1'b0;
    to_fill = 1'b0;
    case (phase)
      ST_CHAN: begin
        if (sel_valid) begin
          if (pos == POS_LAST) begin
            end_blk = 1'b1;
          end else if (sel_last) begin
            if (ch == last_ch) begin
              if (fill_en) to_fill = 1'b1;
              else         end_blk = 1'b1;
            end else begin
              adv_ch = 1'b1;
            end
          end
        end
      end
      ST_FILL: if (pos == POS_LAST) end_blk = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_IDLE;
      pos       <= '0;
      ch        <= '0;
      last_ch   <= '0;
      blk_num   <= '0;
      cfg_q     <= '0;
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_sob   <= 1'b0;
      case (phase)
        ST_IDLE: begin
          if (run) begin
            phase   <= ST_HDR;
            pos     <= '0;
            blk_num <= '0;
            cfg_q   <= cfg_in;
            last_ch <= last_ch_in;
          end
        end
        ST_HDR: begin
          out_valid <= 1'b1;
          out_sob   <= (pos == '0);
          out_data  <= hdr_word;
          pos       <= pos + 1'b1;
          if (pos == HDR_LAST) begin
            phase <= ST_CHAN;
            ch    <= '0;
          end
        end
        ST_CHAN: begin
          if (sel_valid) begin
            out_valid <= 1'b1;
            out_data  <= sel_data;
            pos       <= pos + 1'b1;
            if (adv_ch)  ch    <= ch + 1'b1;
            if (to_fill) phase <= ST_FILL;
          end
        end
        default: begin
          out_valid <= 1'b1;
          out_data  <= FILL_WORD;
          pos       <= pos + 1'b1;
        end
      endcase
      if (end_blk) begin
        if (run) begin
          phase   <= ST_HDR;
          pos     <= '0;
          blk_num <= blk_num + 1'b1;
          cfg_q   <= cfg_in;
          last_ch <= last_ch_in;
        end else begin
          phase <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/blkasm_chk.sv
module blkasm_chk
  import blkasm_pkg::*;
#(
  parameter int BLOCK_WORDS = 2048,
  parameter int NCH         = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH*WORD_W-1:0] ch_data,
  input logic [NCH-1:0]        ch_valid,
  input logic [NCH-1:0]        ch_ready,
  input logic [WORD_W-1:0]     out_data,
  input logic                  out_valid,
  input logic                  out_sob
);
  localparam int CNT_W = $clog2(BLOCK_WORDS + 1);

  // words emitted so far in the current block
  logic [CNT_W-1:0] wcnt;
  always_ff @(posedge clk) begin
    if (rst)            wcnt <= '0;
    else if (out_valid) wcnt <= out_sob ? CNT_W'(1) : wcnt + 1'b1;
  end

  a_r2_sync_lo: assert property (@(posedge clk) disable iff (rst)
    out_sob |-> (out_valid && out_data == SYNC_LO));

  a_r2_sync_hi: assert property (@(posedge clk) disable iff (rst)
    out_sob |=> (out_valid && out_data[23:19] == SYNC_HI));

  a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_ready));

  a_r1_len_bound: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sob) |-> (int'(wcnt) < BLOCK_WORDS));

  for (genvar gi = 0; gi < NCH; gi++) begin : g_pass
    a_r7_pass: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[gi] && ch_ready[gi]) |=>
        (out_valid && out_data == $past(ch_data[gi*WORD_W +: WORD_W])));
  end
endmodule

bind blkasm_top blkasm_chk #(.BLOCK_WORDS(BLOCK_WORDS), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ch_data   (ch_data),
  .ch_valid  (ch_valid),
  .ch_ready  (ch_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_sob   (out_sob)
);

// File: tb/test_blkasm_top.sv
`timescale 1ns/1ps
module test_blkasm_top;
  import blkasm_pkg::*;
  localparam int BW   = 2048;
  localparam int NCH  = 4;
  localparam int MAXG = 3*BW + 16;
  // {act_m1, fill_en, len0, len1, len2, len3}
  localparam logic [52:0] VEC [6] = '{
    {4'd0,  1'b1, 12'd10,   12'd1,   12'd1,  12'd1},
    {4'd3,  1'b1, 12'd5,    12'd6,   12'd7,  12'd8},
    {4'd1,  1'b0, 12'd20,   12'd3,   12'd4,  12'd4},
    {4'd2,  1'b1, 12'd2000, 12'd100, 12'd5,  12'd5},
    {4'd1,  1'b1, 12'd2040, 12'd4,   12'd2,  12'd2},
    {4'd15, 1'b0, 12'd3,    12'd3,   12'd3,  12'd3}
  };

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, fill_en = 1'b1;
  logic [18:0] sess_mclk = '0;
  logic [23:0] sess_div = '0, sess_date = '0, sess_time = '0;
  logic        sess_clk_int = 1'b0;
  logic [3:0]  act_m1 = '0;
  logic [16:0] sess_start_sec = '0;
  logic [7:0]  sess_user = '0;
  logic [5:0]  sess_ver = '0;
  logic [NCH*24-1:0] ch_data = '0;
  logic [NCH-1:0] ch_valid = '0, ch_last = '0, ch_ready;
  logic [23:0] out_data;
  logic        out_valid, out_sob;

  int errors = 0, checks = 0;
  int plen [NCH];
  int rem [NCH];
  int seq [NCH];
  bit xf [NCH];
  logic [23:0] got [MAXG];
  bit          gsob [MAXG];
  int          gcnt = 0;
  logic [23:0] exp_w [BW];
  int          exp_len, fill_start;
  int          srv [NCH];

  always #2.5 clk = ~clk;

  blkasm_top #(.BLOCK_WORDS(BW), .NCH(NCH)) i_blkasm_top (.*);

  // channel sources and output monitor
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++)
      if (xf[i]) begin rem[i]--; seq[i]++; end
    if (out_sob)
      for (int i = 0; i < NCH; i++) begin rem[i] = plen[i]; seq[i] = 0; end
    for (int i = 0; i < NCH; i++) begin
      ch_valid[i] = (rem[i] > 0) && !rst;
      ch_last[i]  = (rem[i] == 1);
      ch_data[i*24 +: 24] = {4'(i), 4'h0, 16'(seq[i])};
      xf[i] = ch_valid[i] && ch_ready[i];
    end
    if (out_valid) begin
      if (gcnt < MAXG) begin got[gcnt] = out_data; gsob[gcnt] = out_sob; end
      gcnt++;
    end
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_exp(input int nact, input bit fill, input logic [23:0] bn);
    int pos, nsrv;
    exp_w[0] = SYNC_LO;
    exp_w[1] = {SYNC_HI, sess_mclk};
    exp_w[2] = bn;
    exp_w[3] = sess_date;
    exp_w[4] = sess_time;
    exp_w[5] = sess_div;
    exp_w[6] = {sess_clk_int, 4'(nact), 2'b00, sess_start_sec};
    exp_w[7] = {sess_user, 10'd0, sess_ver};
    pos  = 8;
    nsrv = (nact + 1 > NCH) ? NCH : nact + 1;
    for (int c = 0; c < NCH; c++) srv[c] = 0;
    for (int c = 0; c < nsrv; c++)
      for (int j = 0; j < plen[c]; j++)
        if (pos < BW) begin exp_w[pos] = {4'(c), 4'h0, 16'(j)}; pos++; srv[c]++; end
    fill_start = pos;
    if (fill) while (pos < BW) begin exp_w[pos] = FILL_WORD; pos++; end
    exp_len = pos;
  endtask

  task automatic set_cfg(input int s);
    sess_mclk      = 19'h12345 + 19'(s);
    sess_div       = 24'h000800 + 24'(s);
    sess_date      = 24'h250314;
    sess_time      = 24'h101500 + 24'(s);
    sess_clk_int   = s[0];
    sess_start_sec = 17'h1ABCD;
    sess_user      = 8'hA0 + 8'(s);
    sess_ver       = 6'd3;
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin plen[i] = 0; rem[i] = 0; seq[i] = 0; xf[i] = 0; end
    step(4);
    // R11: reset state
    chk(out_valid == 1'b0 && out_sob == 1'b0, "R11 reset outputs", {30'd0, out_valid, out_sob}, 0);
    chk(ch_ready == '0, "R11 reset ready", 32'(ch_ready), 0);
    rst = 1'b0;
    step(5);
    chk(gcnt == 0, "R11 idle with run low", gcnt, 0);

    // table of single-block scenarios
    for (int s = 0; s < 6; s++) begin
      logic [52:0] v;
      int nact, mis, mpos;
      bit fl;
      v = VEC[s];
      nact = int'(v[52:49]);
      fl   = v[48];
      plen[0] = int'(v[47:36]); plen[1] = int'(v[35:24]);
      plen[2] = int'(v[23:12]); plen[3] = int'(v[11:0]);
      act_m1 = v[52:49]; fill_en = fl;
      set_cfg(s);
      gcnt = 0;
      run = 1'b1;
      while (gcnt == 0) step();
      run = 1'b0;
      step(BW + 40);
      build_exp(nact, fl, 24'd0);
      chk(gcnt == exp_len, "R1 block length", gcnt, exp_len);
      chk(got[0] == exp_w[0] && got[1] == exp_w[1], "R2 sync and master clock", got[1], exp_w[1]);
      chk(got[2] == exp_w[2], "R3 first block number", got[2], exp_w[2]);
      chk(got[3] == exp_w[3] && got[4] == exp_w[4] && got[5] == exp_w[5], "R4 date/time/divisor",
          got[5], exp_w[5]);
      chk(got[6] == exp_w[6] && got[7] == exp_w[7], "R4 flag and user words", got[6], exp_w[6]);
      mis = 0; mpos = 0;
      for (int w = 1; w < gcnt && w < MAXG; w++) if (gsob[w]) begin mis++; mpos = w; end
      chk(gsob[0] && mis == 0, "R2 single block marker", mpos, 0);
      mis = 0; mpos = 0;
      for (int w = 8; w < fill_start; w++) if (got[w] !== exp_w[w] && mis++ == 0) mpos = w;
      chk(mis == 0, "R7 channel words in priority order", got[mpos], exp_w[mpos]);
      mis = 0; mpos = 0;
      for (int w = fill_start; w < exp_len; w++) if (got[w] !== exp_w[w] && mis++ == 0) mpos = w;
      chk(mis == 0, "R10 fill words", got[mpos], exp_w[mpos]);
      for (int c = 0; c < NCH; c++)
        chk(seq[c] == srv[c], (s == 3 || s == 4) ? "R8 budget per channel" : "R6 served channels",
            seq[c], srv[c]);
    end

    // R3 / R5: three blocks in one session, time changed mid-block
    begin
      logic [23:0] t_old;
      act_m1 = 4'd0; fill_en = 1'b1;
      plen[0] = 3; plen[1] = 1; plen[2] = 1; plen[3] = 1;
      set_cfg(7);
      t_old = sess_time;
      gcnt = 0;
      run = 1'b1;
      while (gcnt < 20) step();
      sess_time = 24'h235959;
      while (gcnt < 2*BW + 5) step();
      run = 1'b0;
      step(BW + 40);
      chk(gcnt == 3*BW, "R1 back-to-back length", gcnt, 3*BW);
      chk(got[BW+2] == 24'd1, "R3 second block number", got[BW+2], 1);
      chk(got[2*BW+2] == 24'd2, "R3 third block number", got[2*BW+2], 2);
      chk(gsob[BW] && gsob[2*BW], "R2 marker on each block", {gsob[BW], gsob[2*BW]}, 2'b11);
      chk(got[4] == t_old, "R5 time held within block", got[4], t_old);
      chk(got[BW+4] == 24'h235959, "R5 time taken at next block", got[BW+4], 24'h235959);
    end

    // R11: reset in mid-block
    gcnt = 0;
    run = 1'b1;
    while (gcnt < 100) step();
    rst = 1'b1; run = 1'b0;
    step();
    chk(out_valid == 1'b0 && ch_ready == '0, "R11 reset mid-block", {27'd0, ch_ready, out_valid}, 0);
    rst = 1'b0;
    gcnt = 0;
    step(30);
    chk(gcnt == 0, "R11 no words after reset with run low", gcnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule